// File: doc/BRIEF.md
# Wavefront Skipping Mask Unit

This unit lets a lane-parallel vector datapath skip groups of elements that a condition has turned off entirely. A wavefront is one element per lane, so `LANES` elements side by side. Before a masked operation runs, a setup pass streams the condition vector into the unit at one wavefront per cycle. Each element is tested against a selected condition code, which gives one enable bit per lane. Wavefronts with no enabled lane are dropped. Every other wavefront is written to a small internal mask memory as a compacted entry holding its wavefront number and its lane enables.

A masked execution then replays only the stored entries, one per cycle, through a valid/ready port. For each entry the unit emits an operand address and the lane enables. The address is the execution base plus the wavefront number times `LANES`. Dropped wavefronts cost no execution cycles. The memory depth `DEPTH` bounds the vector length the unit can accept, which is `DEPTH*LANES` elements. A longer vector is refused with an error flag. Each new setup replaces the single stored mask.

Top module: `wfskip_unit`

## Requirements
- R1: After reset, `out_valid`, `cond_ready`, `setup_busy`, `setup_done`, `setup_err` and `exec_done` are 0 and `entry_count` is 0.
- R2: A setup is accepted when `setup_start` is high in an idle cycle and `cfg_vlen <= DEPTH*LANES`. The unit then consumes exactly ceil(`cfg_vlen`/`LANES`) wavefronts, one at each edge where `cond_ready` and `cond_valid` are both high. `cond_ready` is high only while wavefronts remain. `setup_done` is high for one cycle once all wavefronts are consumed. With `cond_valid` held high, that cycle comes `nwf` cycles after the first setup cycle, so a vector length of 0 finishes in the first setup cycle.
- R3: Condition codes on `cfg_cond`, with each element treated as signed: 0 enables a lane when the element equals zero, 1 when it is nonzero, 2 when it is negative, 3 when it is positive. Lane `l` of wavefront `w` is element `w*LANES+l`, carried on `cond_data[l*ELEM_W +: ELEM_W]` and reported on `out_en[l]`.
- R4: In the last wavefront, lanes whose element index is at or beyond `cfg_vlen` have enable 0 whatever their data.
- R5: Only wavefronts with at least one enabled lane are stored. `entry_count` is cleared when a setup is accepted. From the cycle after `setup_done` it holds the number of stored entries.
- R6: Execution issues the stored entries in ascending wavefront order. `out_addr` = `exec_base` + wavefront*`LANES`, modulo 2^`ADDR_W`. With `out_ready` held high, entry k is shown in the k-th execution cycle (counting from 0) and `exec_done` is high in cycle `entry_count`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_en` stay unchanged. Exactly `entry_count` transfers occur and then `exec_done` is high for one cycle with `out_valid` low. A count of 0 gives `exec_done` in the first execution cycle with no transfer.
- R8: `setup_start` with `cfg_vlen > DEPTH*LANES` in an idle cycle sets `setup_err`, clears `entry_count`, invalidates the stored mask and starts no setup. The next accepted setup clears `setup_err`.
- R9: `exec_reject` is high in the same cycle as `exec_start` when the unit is not idle, when no valid mask is stored, or when `setup_start` is also high. Otherwise execution begins at the next edge. `setup_start` has no effect unless the unit is idle.
- R10: A new setup replaces the stored mask. Execution after it shows only the entries of the new condition vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vlen | input | VLEN_W | Vector length in elements, sampled when a setup is accepted |
| cfg_cond | input | 2 | Condition code, sampled when a setup is accepted |
| setup_start | input | 1 | Request a setup pass |
| cond_valid | input | 1 | A condition wavefront is present on `cond_data` |
| cond_data | input | LANES*ELEM_W | One wavefront of condition elements, lane 0 in the low bits |
| cond_ready | output | 1 | The unit consumes `cond_data` at this edge if `cond_valid` is high |
| setup_busy | output | 1 | A setup pass is in progress |
| setup_done | output | 1 | One-cycle pulse when the setup pass finishes |
| setup_err | output | 1 | The last refused setup had an oversized vector length |
| entry_count | output | $clog2(DEPTH+1) | Number of stored entries |
| exec_start | input | 1 | Request a masked execution |
| exec_base | input | ADDR_W | Base address, sampled when execution is accepted |
| exec_reject | output | 1 | The `exec_start` in this cycle is refused |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | The consumer accepts the presented entry |
| out_addr | output | ADDR_W | Operand address of the presented entry |
| out_en | output | LANES | Lane enables of the presented entry |
| exec_done | output | 1 | One-cycle pulse when all entries have been issued |

## Verification
`setup_done` and `exec_done` are combinational with respect to the unit's counters. The bench counts whole cycles after the cycle in which a request was accepted. It expects `setup_done` after exactly ceil(vlen/LANES) cycles and `exec_done` after exactly the expected entry count when no stall or gap is injected. `entry_count` is read one edge after `setup_done`, because it is registered at that edge. `exec_reject` is sampled in the same cycle as `exec_start`. Inputs change just after the falling edge and outputs are sampled a short delay later, so every compare falls inside the cycle that the requirement names.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    typedef enum logic [1:0] {
        COND_EQZ = 2'd0,
        COND_NEZ = 2'd1,
        COND_LTZ = 2'd2,
        COND_GTZ = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_EXEC  = 2'd2
    } state_e;

    // Lane enable for one element, given its zero and sign flags.
    function automatic logic cond_hit(input cond_e c, input logic is_zero, input logic is_neg);
        case (c)
            COND_EQZ: return is_zero;
            COND_NEZ: return !is_zero;
            COND_LTZ: return is_neg;
            default:  return !is_zero && !is_neg;
        endcase
    endfunction

endpackage

// File: rtl/wfs_compare.sv
module wfs_compare
    import wfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = 8,
    parameter int VLEN_W = 8
) (
    input  logic [1:0]              cond,
    input  logic [LANES*ELEM_W-1:0] data,
    input  logic [VLEN_W-1:0]       vlen,
    input  logic [VLEN_W-1:0]       base_elem,
    output logic [LANES-1:0]        lane_en
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [VLEN_W:0] LOFF = (VLEN_W+1)'(l);
        logic [ELEM_W-1:0] elem;
        logic [VLEN_W:0]   idx;
        logic              in_range;

        assign elem     = data[l*ELEM_W +: ELEM_W];
        assign idx      = {1'b0, base_elem} + LOFF;
        assign in_range = idx < {1'b0, vlen};
        assign lane_en[l] = in_range && cond_hit(cond_e'(cond), elem == '0, elem[ELEM_W-1]);
    end

endmodule

// File: rtl/wfs_maskmem.sv
module wfs_maskmem #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 7,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [ENT_W-1:0] rd_data
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
    import wfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int VLEN_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [VLEN_W-1:0]          cfg_vlen,
    input  logic [1:0]                 cfg_cond,
    input  logic                       setup_start,
    input  logic                       cond_valid,
    input  logic                       lane_any,
    input  logic                       exec_start,
    input  logic [ADDR_W-1:0]          exec_base,
    input  logic                       out_ready,
    output logic [1:0]                 cond_q,
    output logic [VLEN_W-1:0]          vlen_q,
    output logic [VLEN_W-1:0]          base_elem,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   wr_wf,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [ADDR_W-1:0]          base_q,
    output logic                       cond_ready,
    output logic                       setup_busy,
    output logic                       setup_done,
    output logic                       setup_err,
    output logic [$clog2(DEPTH+1)-1:0] entry_count,
    output logic                       exec_reject,
    output logic                       out_valid,
    output logic                       exec_done
);

    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int AW    = $clog2(DEPTH);
    localparam logic [VLEN_W:0]   MAX_V    = (VLEN_W+1)'(DEPTH*LANES);
    localparam logic [VLEN_W:0]   LANES_V  = (VLEN_W+1)'(LANES);
    localparam logic [VLEN_W:0]   LANES_M1 = (VLEN_W+1)'(LANES-1);
    localparam logic [VLEN_W-1:0] LANES_VW = VLEN_W'(LANES);

    state_e           state;
    logic [CNT_W-1:0] wf_idx, wr_ptr, rd_ptr, cnt_q, nwf;
    logic [VLEN_W:0]  nwf_full;
    logic             mask_ok, err_q;
    logic             too_long, exec_ok, wf_left, issue_left;

    always_comb begin
        nwf_full = ({1'b0, vlen_q} + LANES_M1) / LANES_V;
        nwf      = CNT_W'(nwf_full);
    end

    assign too_long   = {1'b0, cfg_vlen} > MAX_V;
    assign exec_ok    = (state == ST_IDLE) && !setup_start && mask_ok;
    assign wf_left    = wf_idx != nwf;
    assign issue_left = rd_ptr != cnt_q;

    assign base_elem   = VLEN_W'(wf_idx) * LANES_VW;
    assign cond_ready  = (state == ST_SETUP) && wf_left;
    assign setup_busy  = state == ST_SETUP;
    assign setup_done  = (state == ST_SETUP) && !wf_left;
    assign wr_en       = cond_ready && cond_valid && lane_any;
    assign wr_addr     = AW'(wr_ptr);
    assign wr_wf       = AW'(wf_idx);
    assign rd_addr     = AW'(rd_ptr);
    assign out_valid   = (state == ST_EXEC) && issue_left;
    assign exec_done   = (state == ST_EXEC) && !issue_left;
    assign exec_reject = exec_start && !exec_ok;
    assign setup_err   = err_q;
    assign entry_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            vlen_q  <= '0;
            cond_q  <= '0;
            wf_idx  <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_q   <= '0;
            base_q  <= '0;
            mask_ok <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (setup_start) begin
                        mask_ok <= 1'b0;
                        cnt_q   <= '0;
                        if (too_long) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q  <= 1'b0;
                            vlen_q <= cfg_vlen;
                            cond_q <= cfg_cond;
                            wf_idx <= '0;
                            wr_ptr <= '0;
                            state  <= ST_SETUP;
                        end
                    end else if (exec_start && mask_ok) begin
                        base_q <= exec_base;
                        rd_ptr <= '0;
                        state  <= ST_EXEC;
                    end
                end
                ST_SETUP: begin
                    if (!wf_left) begin
                        cnt_q   <= wr_ptr;
                        mask_ok <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (cond_valid) begin
                        wf_idx <= wf_idx + CNT_W'(1);
                        if (lane_any) wr_ptr <= wr_ptr + CNT_W'(1);
                    end
                end
                ST_EXEC: begin
                    if (!issue_left) state <= ST_IDLE;
                    else if (out_ready) rd_ptr <= rd_ptr + CNT_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wfskip_unit.sv
module wfskip_unit
    import wfs_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = 8,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int VLEN_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [VLEN_W-1:0]          cfg_vlen,
    input  logic [1:0]                 cfg_cond,
    input  logic                       setup_start,
    input  logic                       cond_valid,
    input  logic [LANES*ELEM_W-1:0]    cond_data,
    output logic                       cond_ready,
    output logic                       setup_busy,
    output logic                       setup_done,
    output logic                       setup_err,
    output logic [$clog2(DEPTH+1)-1:0] entry_count,
    input  logic                       exec_start,
    input  logic [ADDR_W-1:0]          exec_base,
    output logic                       exec_reject,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [ADDR_W-1:0]          out_addr,
    output logic [LANES-1:0]           out_en,
    output logic                       exec_done
);

    localparam int AW    = $clog2(DEPTH);
    localparam int ENT_W = AW + LANES;
    localparam logic [ADDR_W-1:0] LANES_A = ADDR_W'(LANES);

    typedef struct packed {
        logic [AW-1:0]    wf;
        logic [LANES-1:0] en;
    } entry_t;

    logic [1:0]        cond_q;
    logic [VLEN_W-1:0] vlen_q, base_elem;
    logic [LANES-1:0]  lane_en;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, wr_wf, rd_addr;
    logic [ADDR_W-1:0] base_q;
    entry_t            wr_ent, rd_ent;

    wfs_compare #(.LANES(LANES), .ELEM_W(ELEM_W), .VLEN_W(VLEN_W)) u_cmp (
        .cond      (cond_q),
        .data      (cond_data),
        .vlen      (vlen_q),
        .base_elem (base_elem),
        .lane_en   (lane_en)
    );

    wfs_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .VLEN_W(VLEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_vlen    (cfg_vlen),
        .cfg_cond    (cfg_cond),
        .setup_start (setup_start),
        .cond_valid  (cond_valid),
        .lane_any    (|lane_en),
        .exec_start  (exec_start),
        .exec_base   (exec_base),
        .out_ready   (out_ready),
        .cond_q      (cond_q),
        .vlen_q      (vlen_q),
        .base_elem   (base_elem),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_wf       (wr_wf),
        .rd_addr     (rd_addr),
        .base_q      (base_q),
        .cond_ready  (cond_ready),
        .setup_busy  (setup_busy),
        .setup_done  (setup_done),
        .setup_err   (setup_err),
        .entry_count (entry_count),
        .exec_reject (exec_reject),
        .out_valid   (out_valid),
        .exec_done   (exec_done)
    );

    assign wr_ent = '{wf: wr_wf, en: lane_en};

    wfs_maskmem #(.DEPTH(DEPTH), .ENT_W(ENT_W), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_ent),
        .rd_addr (rd_addr),
        .rd_data (rd_ent)
    );

    assign out_en   = rd_ent.en;
    assign out_addr = base_q + ADDR_W'(rd_ent.wf) * LANES_A;

endmodule

// File: rtl/wfs_checker.sv
module wfs_checker #(
    parameter int LANES  = 4,
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cond_ready,
    input logic                       setup_busy,
    input logic                       setup_err,
    input logic [$clog2(DEPTH+1)-1:0] entry_count,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [ADDR_W-1:0]          out_addr,
    input logic [LANES-1:0]           out_en,
    input logic                       exec_done
);

    // R2: wavefronts are only taken inside a setup pass
    a_r2_ready_in_setup: assert property (@(posedge clk) disable iff (rst)
        cond_ready |-> setup_busy);

    // R5: an issued entry always has an enabled lane
    a_r5_no_empty_issue: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_en != '0);

    // R5: the count never exceeds the memory depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        entry_count <= DEPTH);

    // R7: a stalled entry holds still
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_en));

    // R7: completion carries no entry
    a_r7_done_not_valid: assert property (@(posedge clk) disable iff (rst)
        exec_done |-> !out_valid);

    // R8: an error state never issues
    a_r8_err_no_issue: assert property (@(posedge clk) disable iff (rst)
        setup_err |-> !out_valid);

    // R9: nothing issues while a setup pass runs
    a_r9_no_issue_in_setup: assert property (@(posedge clk) disable iff (rst)
        setup_busy |-> !out_valid);

endmodule

bind wfskip_unit wfs_checker #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cond_ready  (cond_ready),
    .setup_busy  (setup_busy),
    .setup_err   (setup_err),
    .entry_count (entry_count),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_en      (out_en),
    .exec_done   (exec_done)
);

// File: tb/tb_wfskip_unit.sv
`timescale 1ns/1ps
module tb_wfskip_unit;

    localparam int LANES  = 4;
    localparam int ELEM_W = 8;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 16;
    localparam int VLEN_W = 8;
    localparam int CNT_W  = $clog2(DEPTH+1);
    localparam int MAXV   = DEPTH*LANES;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                    rst;
    logic [VLEN_W-1:0]       cfg_vlen;
    logic [1:0]              cfg_cond;
    logic                    setup_start, cond_valid;
    logic [LANES*ELEM_W-1:0] cond_data;
    logic                    cond_ready, setup_busy, setup_done, setup_err;
    logic [CNT_W-1:0]        entry_count;
    logic                    exec_start;
    logic [ADDR_W-1:0]       exec_base;
    logic                    exec_reject, out_valid, out_ready, exec_done;
    logic [ADDR_W-1:0]       out_addr;
    logic [LANES-1:0]        out_en;

    wfskip_unit #(.LANES(LANES), .ELEM_W(ELEM_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .VLEN_W(VLEN_W)) dut (
        .clk(clk), .rst(rst), .cfg_vlen(cfg_vlen), .cfg_cond(cfg_cond),
        .setup_start(setup_start), .cond_valid(cond_valid), .cond_data(cond_data),
        .cond_ready(cond_ready), .setup_busy(setup_busy), .setup_done(setup_done),
        .setup_err(setup_err), .entry_count(entry_count), .exec_start(exec_start),
        .exec_base(exec_base), .exec_reject(exec_reject), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_en(out_en), .exec_done(exec_done)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic signed [ELEM_W-1:0] vec [MAXV];
    int               exp_wf [DEPTH];
    logic [LANES-1:0] exp_en [DEPTH];
    int               exp_n;
    int unsigned      rng = 32'h1234_5678;

    function automatic int unsigned nxt();
        rng = rng * 32'd1103515245 + 32'd12345;
        return rng >> 16;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit hit(input int c, input logic signed [ELEM_W-1:0] v);
        case (c)
            0: return v == 0;
            1: return v != 0;
            2: return v < 0;
            default: return v > 0;
        endcase
    endfunction

    task automatic gen_vec(input int mode);
        for (int i = 0; i < MAXV; i++) begin
            int unsigned r;
            r = nxt();
            case (mode)
                0: vec[i] = (r % 3 == 0) ? '0 : ELEM_W'(r >> 4);
                1: vec[i] = (i % 5 == 0) ? '0 : ELEM_W'(i + 1);
                default: vec[i] = (r % 7 == 0) ? ELEM_W'(r >> 2) : '0;
            endcase
        end
    endtask

    task automatic build_exp(input int vlen, input int c);
        exp_n = 0;
        for (int w = 0; w < (vlen + LANES - 1) / LANES; w++) begin
            logic [LANES-1:0] en;
            en = '0;
            for (int l = 0; l < LANES; l++) begin
                int i;
                i = w * LANES + l;
                if (i < vlen && hit(c, vec[i])) en[l] = 1'b1;
            end
            if (en != '0) begin
                exp_wf[exp_n] = w;
                exp_en[exp_n] = en;
                exp_n++;
            end
        end
    endtask

    function automatic logic [LANES*ELEM_W-1:0] pack_wf(input int w);
        logic [LANES*ELEM_W-1:0] d;
        d = '0;
        for (int l = 0; l < LANES; l++) begin
            int i;
            i = w * LANES + l;
            if (i < MAXV) d[l*ELEM_W +: ELEM_W] = vec[i];
        end
        return d;
    endfunction

    task automatic do_setup(input int vlen, input int c, input bit gaps, input bit probe);
        int nwf, fed, cyc;
        bit done;
        build_exp(vlen, c);
        nwf = (vlen + LANES - 1) / LANES;
        @(negedge clk);
        cfg_vlen = VLEN_W'(vlen);
        cfg_cond = 2'(c);
        setup_start = 1'b1;
        @(negedge clk);
        setup_start = 1'b0;
        fed = 0; cyc = 0; done = 0;
        while (!done && cyc < 200) begin
            cond_valid = gaps ? ((nxt() % 2) == 1) : 1'b1;
            cond_data  = pack_wf(fed);
            exec_start = probe && cyc == 0;
            #1;
            if (probe && cyc == 0) check(exec_reject == 1'b1, "R9 reject during setup", exec_reject, 1);
            if (setup_done) done = 1;
            else if (cond_ready && cond_valid) fed++;
            if (!done) begin
                @(negedge clk);
                cyc++;
            end
        end
        exec_start = 1'b0;
        cond_valid = 1'b0;
        check(done, "R2 setup completes", done, 1);
        check(fed == nwf, "R2 wavefronts consumed", fed, nwf);
        if (!gaps) check(cyc == nwf, "R2 one wavefront per cycle", cyc, nwf);
        @(negedge clk);
        #1;
        check(entry_count == CNT_W'(exp_n), "R5 stored entry count", entry_count, exp_n);
        check(setup_busy == 1'b0 && setup_err == 1'b0, "R8 idle without error after setup",
              {setup_busy, setup_err}, 0);
    endtask

    task automatic do_exec(input int base, input bit stall, input bit poke);
        int k, cyc;
        bit done;
        @(negedge clk);
        exec_start = 1'b1;
        exec_base  = ADDR_W'(base);
        out_ready  = 1'b0;
        #1;
        check(exec_reject == 1'b0, "R9 execute accepted", exec_reject, 0);
        @(negedge clk);
        exec_start = 1'b0;
        k = 0; cyc = 0; done = 0;
        while (!done && cyc < 400) begin
            out_ready   = stall ? ((nxt() % 3) != 0) : 1'b1;
            setup_start = poke && cyc == 1;
            cfg_vlen    = '0;
            #1;
            if (exec_done) begin
                done = 1;
                check(out_valid == 1'b0, "R7 done without entry", out_valid, 0);
            end else if (out_valid && out_ready) begin
                if (k < exp_n) begin
                    logic [ADDR_W-1:0] ea;
                    ea = ADDR_W'(base + exp_wf[k] * LANES);
                    check(out_addr == ea, "R6 operand address", out_addr, ea);
                    check(out_en == exp_en[k], "R3 R4 R6 lane enables", out_en, exp_en[k]);
                end else begin
                    check(0, "R7 extra transfer", k, exp_n);
                end
                k++;
            end
            if (!done) begin
                @(negedge clk);
                cyc++;
            end
        end
        setup_start = 1'b0;
        out_ready   = 1'b0;
        check(done, "R7 execute completes", done, 1);
        check(k == exp_n, "R7 transfer count", k, exp_n);
        if (!stall) check(cyc == exp_n, "R6 one entry per cycle", cyc, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_vlen = '0; cfg_cond = '0; setup_start = 1'b0; cond_valid = 1'b0;
        cond_data = '0; exec_start = 1'b0; exec_base = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check({out_valid, cond_ready, setup_busy, setup_done, setup_err, exec_done} == 6'b0,
              "R1 reset outputs", {out_valid, cond_ready, setup_busy, setup_done, setup_err, exec_done}, 0);
        check(entry_count == '0, "R1 reset count", entry_count, 0);

        // R9: nothing stored yet
        exec_start = 1'b1;
        #1;
        check(exec_reject == 1'b1, "R9 reject without mask", exec_reject, 1);
        @(negedge clk);
        exec_start = 1'b0;
        #1;
        check(out_valid == 1'b0, "R9 no issue after reject", out_valid, 0);

        // R8: oversized vector
        @(negedge clk);
        cfg_vlen = VLEN_W'(MAXV + 1);
        setup_start = 1'b1;
        @(negedge clk);
        setup_start = 1'b0;
        #1;
        check(setup_err == 1'b1 && setup_busy == 1'b0, "R8 error on oversized length",
              {setup_err, setup_busy}, 2);
        check(entry_count == '0, "R8 count cleared", entry_count, 0);
        exec_start = 1'b1;
        #1;
        check(exec_reject == 1'b1, "R8 execute refused after error", exec_reject, 1);
        @(negedge clk);
        exec_start = 1'b0;

        // Sweep over data patterns, condition codes and lengths
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 4; c++) begin
                for (int v = 0; v < 8; v++) begin
                    int lens [8] = '{0, 1, 3, 4, 5, 13, 31, 32};
                    gen_vec(m);
                    do_setup(lens[v], c, m == 2, v == 3);
                    do_exec(m * 20000 + c * 4093 + v * 7, m != 0, m == 1 && v == 6);
                end
            end
        end

        // R10: replace a stored mask and replay
        gen_vec(1);
        do_setup(32, 1, 1'b0, 1'b0);
        do_exec(16'hFFF0, 1'b0, 1'b0);
        gen_vec(1);
        do_setup(10, 0, 1'b0, 1'b0);
        check(entry_count == CNT_W'(exp_n), "R10 count after overwrite", entry_count, exp_n);
        do_exec(100, 1'b1, 1'b0);

        // R8: an error drops a valid mask
        @(negedge clk);
        cfg_vlen = VLEN_W'(MAXV + 9);
        setup_start = 1'b1;
        @(negedge clk);
        setup_start = 1'b0;
        exec_start = 1'b1;
        #1;
        check(exec_reject == 1'b1 && setup_err == 1'b1, "R8 mask invalidated by error",
              {exec_reject, setup_err}, 3);
        @(negedge clk);
        exec_start = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule